// File: doc/BRIEF.md
# Nested Priority Interrupt Vector Controller

This block takes 32 interrupt request lines and picks one of them for service. Each source has a 4-bit priority level, where 0 is the most urgent and 15 the least urgent. Each level can be switched off through a 16-bit level-enable mask. The pending source with the most urgent enabled level wins. When several winners share a level, the one with the lowest index is chosen. The block raises `irq_out` only when that winner is strictly more urgent than the level now in service.

Software programs a 32-bit handler address and a priority level for each source over a small synchronous register bus. It then reads a single vector register to fetch the handler address of the current winner. When `irq_out` is high, that read also records the winner's level on an internal stack of service levels. Any write to the vector register ends the current handler and restores the level that was in service before it. This lets a more urgent request preempt a running handler, and the levels unwind in order.

The register bus is a control port, not a stream, so it has no valid/ready handshake and no back-pressure. A strobe is accepted on the clock edge where it is high. Read data appears on `bus_rdata` in the next cycle and holds until the next read. If `bus_wr` and `bus_rd` are both high, the write is performed and the read is ignored. The source count must be a power of two.

Top module: `ivc_top`

## Requirements
- R1: After synchronous reset the following hold:
  - every handler register reads 0 and every priority register reads 15;
  - the level mask reads 0xFFFF and `irq_out` is low while no request is pending;
  - a vector read returns 0.
- R2: Word addresses 0 to 31 hold the 32-bit handler address of sources 0 to 31. A write stores all 32 bits, and a read returns them on `bus_rdata` one cycle after the `bus_rd` strobe.
- R3: Word addresses 32 to 63 hold the priority level of sources 0 to 31. Only `bus_wdata[3:0]` is stored, and bits 31:4 read back as zero.
- R4: `irq_out` is high when a pending, enabled source exists and no level is in service. A vector read (word address 65) then returns the handler address of the pending source with the numerically lowest level.
- R5: When several pending, enabled sources share the best level, the source with the lowest index is selected.
- R6: Word address 64 holds the level mask in bits 15:0, where bit k enables level k. A pending source whose level bit is 0 is neither selected nor able to raise `irq_out`.
- R7: A vector read while `irq_out` is high pushes the selected level as the level in service. From then on, `irq_out` is high only for a selected level that is numerically lower than it. Nesting reaches 16 levels.
- R8: A write of any value to the vector register pops the level in service, which restores the previous one. With the stack emptied, any pending enabled source may assert `irq_out` again.
- R9: A vector read while `irq_out` is low returns the handler address of the last serviced source and does not change the level in service.
- R10: A write to the vector register while no level is in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Interrupt request lines, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions take the register bus to carry one strobe per cycle at most. They also rely on the fact that the stack only grows through a read taken while `irq_out` is high. Under those two conditions the pushed levels stay strictly decreasing, so the depth can never pass 16. The stimulus never raises `bus_wr` and `bus_rd` together. It reaches full depth only through a ladder of sixteen strictly more urgent sources. In its random phase, vector reads, acknowledges, level rewrites and mask rewrites are mixed freely while the request lines change underneath them.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [2:0] {
    RG_HANDLER,
    RG_LEVEL,
    RG_MASK,
    RG_VECTOR,
    RG_NONE
  } region_e;

  // Word map: handlers, then levels, then mask, then the vector register.
  function automatic region_e decode(input int unsigned addr, input int unsigned nsrc);
    if (addr < nsrc) return RG_HANDLER;
    else if (addr < 2 * nsrc) return RG_LEVEL;
    else if (addr == 2 * nsrc) return RG_MASK;
    else if (addr == 2 * nsrc + 1) return RG_VECTOR;
    else return RG_NONE;
  endfunction

endpackage

// File: rtl/ivc_regfile.sv
module ivc_regfile #(
  parameter int N_SRC  = 32,
  parameter int HW     = 32,
  parameter int PW     = 4,
  parameter int LEVELS = 1 << PW,
  parameter int SW     = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_handler,
  input  logic          wr_level,
  input  logic          wr_mask,
  input  logic [SW-1:0] wr_idx,
  input  logic [HW-1:0] wdata,
  output logic [HW-1:0] handler [N_SRC],
  output logic [PW-1:0] level   [N_SRC],
  output logic [LEVELS-1:0] mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) begin
        handler[i] <= '0;
        level[i]   <= '1;
      end
      mask <= '1;
    end else begin
      if (wr_handler) handler[wr_idx] <= wdata;
      if (wr_level)   level[wr_idx]   <= wdata[PW-1:0];
      if (wr_mask)    mask            <= wdata[LEVELS-1:0];
    end
  end

endmodule

// File: rtl/ivc_select.sv
module ivc_select #(
  parameter int N_SRC  = 32,
  parameter int PW     = 4,
  parameter int LEVELS = 1 << PW,
  parameter int SW     = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  req,
  input  logic [PW-1:0]     level [N_SRC],
  input  logic [LEVELS-1:0] mask,
  output logic              win_valid,
  output logic [SW-1:0]     win_idx,
  output logic [PW-1:0]     win_prio
);

  logic [N_SRC-1:0] pend;

  for (genvar g = 0; g < N_SRC; g++) begin : g_pend
    assign pend[g] = req[g] & mask[level[g]];
  end

  // Strict compare keeps the lowest index among equal levels.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && (!win_valid || level[i] < win_prio)) begin
        win_valid = 1'b1;
        win_idx   = SW'(i);
        win_prio  = level[i];
      end
    end
  end

endmodule

// File: rtl/ivc_level_stack.sv
module ivc_level_stack #(
  parameter int PW    = 4,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [PW-1:0] push_lvl,
  input  logic          pop,
  output logic [CW-1:0] depth,
  output logic [PW-1:0] top_lvl,
  output logic          empty
);

  localparam int IW = $clog2(DEPTH);

  logic [PW-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
    end else if (push && depth < CW'(DEPTH)) begin
      slot[depth[IW-1:0]] <= push_lvl;
      depth <= depth + CW'(1);
    end else if (pop && depth != '0) begin
      depth <= depth - CW'(1);
    end
  end

  assign empty   = (depth == '0);
  assign top_lvl = empty ? '0 : slot[IW'(depth - CW'(1))];

endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
  parameter int N_SRC  = 32,
  parameter int HW     = 32,
  parameter int PW     = 4,
  parameter int BUS_AW = $clog2(2 * N_SRC + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [HW-1:0]     bus_wdata,
  output logic [HW-1:0]     bus_rdata,
  output logic              irq_out
);
  import ivc_pkg::*;

  localparam int LEVELS = 1 << PW;
  localparam int SW     = $clog2(N_SRC);
  localparam int CW     = $clog2(LEVELS + 1);

  region_e       rgn;
  logic [SW-1:0] idx;
  logic [HW-1:0] handler [N_SRC];
  logic [PW-1:0] level   [N_SRC];
  logic [LEVELS-1:0] mask;
  logic          win_valid;
  logic [SW-1:0] win_idx;
  logic [PW-1:0] win_prio;
  logic [CW-1:0] depth;
  logic [PW-1:0] top_lvl;
  logic          empty;
  logic [PW:0]   cur_lvl;
  logic          vec_rd, ack, push, pop;
  logic [HW-1:0] last_handler, rd_val;

  assign rgn = decode(int'(bus_addr), N_SRC);
  assign idx = bus_addr[SW-1:0];

  ivc_regfile #(.N_SRC(N_SRC), .HW(HW), .PW(PW), .LEVELS(LEVELS), .SW(SW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_handler (bus_wr && rgn == RG_HANDLER),
    .wr_level   (bus_wr && rgn == RG_LEVEL),
    .wr_mask    (bus_wr && rgn == RG_MASK),
    .wr_idx     (idx),
    .wdata      (bus_wdata),
    .handler    (handler),
    .level      (level),
    .mask       (mask)
  );

  ivc_select #(.N_SRC(N_SRC), .PW(PW), .LEVELS(LEVELS), .SW(SW)) u_sel (
    .req       (irq_src),
    .level     (level),
    .mask      (mask),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  ivc_level_stack #(.PW(PW), .DEPTH(LEVELS), .CW(CW)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_lvl (win_prio),
    .pop      (pop),
    .depth    (depth),
    .top_lvl  (top_lvl),
    .empty    (empty)
  );

  // An idle stack means a virtual level one beyond the least urgent.
  assign cur_lvl = empty ? (PW + 1)'(LEVELS) : {1'b0, top_lvl};
  assign irq_out = win_valid && ({1'b0, win_prio} < cur_lvl);

  assign vec_rd = bus_rd && !bus_wr && rgn == RG_VECTOR;
  assign ack    = bus_wr && rgn == RG_VECTOR;
  assign push   = vec_rd && irq_out;
  assign pop    = ack && !empty;

  always_comb begin
    rd_val = '0;
    case (rgn)
      RG_HANDLER: rd_val = handler[idx];
      RG_LEVEL:   rd_val = HW'(level[idx]);
      RG_MASK:    rd_val = HW'(mask);
      RG_VECTOR:  rd_val = irq_out ? handler[win_idx] : last_handler;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      last_handler <= '0;
    end else begin
      if (bus_rd && !bus_wr) bus_rdata <= rd_val;
      if (push) last_handler <= handler[win_idx];
    end
  end

endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
  parameter int CW     = 5,
  parameter int LEVELS = 16,
  parameter int HW     = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_out,
  input logic          vec_rd,
  input logic          ack,
  input logic [CW-1:0] depth,
  input logic [HW-1:0] bus_rdata
);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(LEVELS));

  assert_push_on_take_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && irq_out) |=> depth == $past(depth) + CW'(1));

  assert_pop_on_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && depth != '0) |=> depth == $past(depth) - CW'(1));

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !irq_out) |=> $stable(depth));

  assert_empty_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && depth == '0) |=> depth == '0);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (depth == '0 && bus_rdata == '0));

endmodule

bind ivc_top ivc_chk #(.CW(CW), .LEVELS(LEVELS), .HW(HW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .vec_rd    (vec_rd),
  .ack       (ack),
  .depth     (depth),
  .bus_rdata (bus_rdata)
);

// File: tb/ivc_top_bench.sv
module ivc_top_bench;

  localparam int ADDR_MASK = 64;
  localparam int ADDR_VEC  = 65;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] irq_src = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  ivc_top u_ivc_top (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Behavioural reference state
  logic [31:0] m_hand [32];
  int          m_lvl  [32];
  logic [15:0] m_mask;
  int          m_stk  [$];
  logic [31:0] m_last, m_rdata;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin m_hand[i] = '0; m_lvl[i] = 15; end
    m_mask = 16'hFFFF; m_stk = {}; m_last = '0; m_rdata = '0;
  endtask

  function automatic bit model_irq(output int wi);
    int best = 16, cur;
    wi = 0;
    for (int i = 0; i < 32; i++)
      if (irq_src[i] && m_mask[m_lvl[i]] && m_lvl[i] < best) begin best = m_lvl[i]; wi = i; end
    cur = (m_stk.size() == 0) ? 16 : m_stk[$];
    return (best < cur);
  endfunction

  // One bus cycle: drive, compare, advance the model, cross the edge.
  task automatic cyc(input bit wr, input bit rd, input int addr, input logic [31:0] wd);
    int wi;
    bit ei;
    bus_wr = wr; bus_rd = rd; bus_addr = 7'(addr); bus_wdata = wd;
    #1;
    ei = model_irq(wi);
    chk("irq_out", {31'b0, irq_out}, {31'b0, ei});
    chk("rdata", bus_rdata, m_rdata);
    if (wr) begin
      if (addr < 32) m_hand[addr] = wd;
      else if (addr < 64) m_lvl[addr-32] = int'(wd[3:0]);
      else if (addr == ADDR_MASK) m_mask = wd[15:0];
      else if (addr == ADDR_VEC && m_stk.size() > 0) void'(m_stk.pop_back());
    end else if (rd) begin
      if (addr < 32) m_rdata = m_hand[addr];
      else if (addr < 64) m_rdata = 32'(m_lvl[addr-32]);
      else if (addr == ADDR_MASK) m_rdata = {16'b0, m_mask};
      else if (addr == ADDR_VEC) begin
        if (ei) begin m_rdata = m_hand[wi]; m_last = m_hand[wi]; m_stk.push_back(m_lvl[wi]); end
        else m_rdata = m_last;
      end else m_rdata = '0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, '0); endtask
  task automatic wr(input int a, input logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input int a, output logic [31:0] d);
    cyc(0, 1, a, '0); #1 d = bus_rdata;
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got 0x0 expected 0x1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset contents
    #1 chk("R1 irq_out low", {31'b0, irq_out}, 32'h0);
    rd(5, d);          chk("R1 handler reset", d, 32'h0);
    rd(32 + 7, d);     chk("R1 level reset", d, 32'hF);
    rd(ADDR_MASK, d);  chk("R1 mask reset", d, 32'h0000_FFFF);
    rd(ADDR_VEC, d);   chk("R1 vector reset", d, 32'h0);

    // R2 handler storage
    for (int i = 0; i < 32; i++) wr(i, 32'h1000_0000 + 32'(i * 16));
    rd(0, d);  chk("R2 handler 0", d, 32'h1000_0000);
    rd(31, d); chk("R2 handler 31", d, 32'h1000_01F0);

    // R3 priority field width
    wr(32 + 3, 32'hFFFF_FFF5);
    rd(32 + 3, d); chk("R3 level bits", d, 32'h5);
    wr(32 + 20, 32'h5);

    // R4 / R5 selection and tie-break
    irq_src = (32'h1 << 9) | (32'h1 << 20) | (32'h1 << 3);
    idle();
    #1 chk("R4 irq raised", {31'b0, irq_out}, 32'h1);
    rd(ADDR_VEC, d); chk("R5 lowest index of tie", d, 32'h1000_0030);
    #1 chk("R7 equal level blocked", {31'b0, irq_out}, 32'h0);

    // R7 preemption by more urgent level
    wr(32 + 9, 32'h2);
    #1 chk("R7 preempt", {31'b0, irq_out}, 32'h1);
    rd(ADDR_VEC, d); chk("R7 nested vector", d, 32'h1000_0090);
    rd(ADDR_VEC, d); chk("R9 last handler", d, 32'h1000_0090);

    // R8 unwind
    irq_src = (32'h1 << 20) | (32'h1 << 3);
    wr(ADDR_VEC, 32'hDEAD);
    #1 chk("R8 level 5 restored", {31'b0, irq_out}, 32'h0);
    wr(ADDR_VEC, 32'h0);
    #1 chk("R8 stack empty", {31'b0, irq_out}, 32'h1);

    // R10 ack with empty stack
    wr(ADDR_VEC, 32'h1234);
    #1 chk("R10 no effect irq", {31'b0, irq_out}, 32'h1);
    rd(ADDR_VEC, d); chk("R10 vector unchanged", d, 32'h1000_0030);
    wr(ADDR_VEC, 32'h0);

    // R6 level masking
    wr(ADDR_MASK, 32'h0000_FFDF);
    #1 chk("R6 level 5 masked", {31'b0, irq_out}, 32'h0);
    irq_src = irq_src | (32'h1 << 9);
    idle();
    #1 chk("R6 other level live", {31'b0, irq_out}, 32'h1);
    wr(ADDR_MASK, 32'h0000_FFFF);

    // R7 full 16-deep ladder
    irq_src = '0;
    for (int i = 0; i < 16; i++) wr(32 + i, 32'(15 - i));
    for (int i = 0; i < 16; i++) begin
      irq_src = irq_src | (32'h1 << i);
      idle();
      rd(ADDR_VEC, d); chk("R7 ladder vector", d, 32'h1000_0000 + 32'(i * 16));
    end
    #1 chk("R7 level 0 blocks all", {31'b0, irq_out}, 32'h0);
    for (int i = 0; i < 16; i++) wr(ADDR_VEC, 32'h0);
    #1 chk("R8 ladder unwound", {31'b0, irq_out}, 32'h1);

    // Mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 10);
      if ($urandom % 4 == 0) irq_src = $urandom & $urandom & $urandom;
      case (op)
        0, 1: cyc(0, 1, ADDR_VEC, '0);
        2:    cyc(1, 0, ADDR_VEC, $urandom);
        3:    cyc(1, 0, 32 + int'($urandom % 32), $urandom);
        4:    cyc(1, 0, ADDR_MASK, $urandom | 32'h8001);
        5:    cyc(0, 1, int'($urandom % 66), '0);
        default: idle();
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule